// File: doc/BRIEF.md
# Serial Byte Transmitter with Marker-Terminated Shift Register

This block turns bytes offered on a valid/ready stream into asynchronous serial frames on a single output line. Each frame begins with a low start bit, carries the data bits least significant first, optionally adds a parity bit, and ends with one or two high stop bits. Parity mode and stop-bit count are fixed at elaboration time.

The complete frame is loaded at once into one shift register, with an extra 1 placed above the last stop bit. The register shifts toward the line on every bit-period expiry. The frame is finished when only that marker 1 remains, so no bit counter is needed. Bit timing comes from a fractional accumulator: it adds `baud_inc` every clock, and each overflow ends one bit period. The accumulator is cleared at the moment a byte is accepted, so the start bit always lasts a full period from that clock. In the last clock of the final stop bit, the transmitter already accepts the next byte, so streamed bytes leave with no idle clocks between frames.

Top module: `serial_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx` is 1 and `in_ready` is 1.
- R2: A frame is, in time order: a start bit of 0, then `in_data` bit 0 up to bit DATA_W-1, then the parity bit when enabled, then STOP_BITS stop bits of value 1.
- R3: With PARITY = PAR_EVEN, the parity bit makes the number of ones across data and parity even.
- R4: With PARITY = PAR_ODD, the parity bit makes the number of ones across data and parity odd.
- R5: Let a byte be accepted at clock edge k. In the interval after edge k+m, the line carries frame bit floor(m·baud_inc / 2^ACC_W), for as long as that index is below the frame length. After that the line is 1.
- R6: The start bit appears on `tx` in the clock right after the accepting edge, without waiting for any free-running tick.
- R7: `in_ready` is 0 while a frame is being sent, except in the final clock of the last stop bit. A byte accepted in that clock starts its start bit directly after that stop bit, with no idle clock in between.
- R8: `in_data` has no effect unless `in_valid` and `in_ready` are both 1 at a clock edge. Every frame sent matches exactly one accepted byte, in order.
- R9: `tx` changes only at an accepting edge or at the end of a bit period, and the shift register never becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_inc | input | ACC_W | Per-clock accumulator increment; bit period is 2^ACC_W / baud_inc clocks on average |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Transmitter can take a byte at this edge |
| tx | output | 1 | Serial line, registered |

## Verification
The assertions assume that `baud_inc` is nonzero and held constant while a frame is in flight. They also assume that `in_valid` and `in_data` are driven only from outside the clock edge. The stimulus sets a fixed increment below 2^ACC_W for each instance and changes inputs only on the falling clock edge. The bench sends bytes both as a continuous stream, to exercise the zero-gap handover, and with holes of varying length. While no byte is accepted, it scrambles `in_data` so that ignored values would show up as frame errors.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } parity_e;

  // Number of parity bits a mode adds to a frame
  function automatic int parity_bits(parity_e mode);
    return (mode == PAR_NONE) ? 0 : 1;
  endfunction

endpackage

// File: rtl/baud_accum.sv
// Fractional bit-period generator: adds inc each running clock; a carry out
// of the top bit ends one bit period. restart clears the phase.
module baud_accum #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [ACC_W-1:0] inc,
  output logic             tick
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, acc} + {1'b0, inc};
  assign tick = run & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc <= '0;
    end else if (run) begin
      acc <= sum[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/frame_pack.sv
// Builds the whole frame, start bit in bit 0, stop bits at the top.
module frame_pack
  import serial_tx_pkg::*;
#(
  parameter int      DATA_W    = 8,
  parameter parity_e PARITY    = PAR_EVEN,
  parameter int      STOP_BITS = 1,
  localparam int     FRAME_W   = 1 + DATA_W + parity_bits(PARITY) + STOP_BITS
) (
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame
);

  generate
    if (PARITY == PAR_NONE) begin : g_nopar
      assign frame = {{STOP_BITS{1'b1}}, data, 1'b0};
    end else begin : g_par
      logic par_bit;
      assign par_bit = (^data) ^ (PARITY == PAR_ODD);
      assign frame   = {{STOP_BITS{1'b1}}, par_bit, data, 1'b0};
    end
  endgenerate

endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int      DATA_W    = 8,
  parameter int      ACC_W     = 16,
  parameter parity_e PARITY    = PAR_EVEN,
  parameter int      STOP_BITS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  baud_inc,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              tx
);

  localparam int FRAME_W = 1 + DATA_W + parity_bits(PARITY) + STOP_BITS;
  localparam int SR_W    = FRAME_W + 1;

  logic [FRAME_W-1:0] frame;
  logic [SR_W-1:0]    shreg;
  logic               tx_q;
  logic               tick;
  logic               accept;
  logic               idle;
  logic               last_bit;

  frame_pack #(
    .DATA_W   (DATA_W),
    .PARITY   (PARITY),
    .STOP_BITS(STOP_BITS)
  ) u_pack (
    .data (in_data),
    .frame(frame)
  );

  baud_accum #(
    .ACC_W(ACC_W)
  ) u_baud (
    .clk    (clk),
    .rst    (rst),
    .restart(accept),
    .run    (~idle),
    .inc    (baud_inc),
    .tick   (tick)
  );

  // Only the marker remains: line idle. Marker plus one bit: last stop bit.
  assign idle     = (shreg == SR_W'(1));
  assign last_bit = (shreg == SR_W'(3));
  assign in_ready = idle | (last_bit & tick);
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= SR_W'(1);
      tx_q  <= 1'b1;
    end else if (accept) begin
      shreg <= {1'b1, frame};
      tx_q  <= frame[0];
    end else if (tick) begin
      shreg <= shreg >> 1;
      tx_q  <= shreg[1];
    end
  end

  assign tx = tx_q;

endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk #(
  parameter int SR_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            tx,
  input logic            tick,
  input logic [SR_W-1:0] shreg
);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    (shreg == SR_W'(1)) |-> (tx && in_ready));

  // R6
  start_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !tx);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(in_valid && in_ready)) |=> $stable(tx));

  // R9
  marker_kept_chk: assert property (@(posedge clk) disable iff (rst)
    shreg != '0);

  // R5
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (shreg == SR_W'(1)) |-> !tick);

endmodule

bind serial_tx serial_tx_chk #(.SR_W(SR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .tx      (tx),
  .tick    (tick),
  .shreg   (shreg)
);

// File: tb/serial_tx_test.sv
`timescale 1ns/1ps
module serial_tx_test;
  import serial_tx_pkg::*;

  localparam int ACC_W = 8;
  localparam int NB    = 24;
  localparam int WD    = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [1:0] vld;
  logic [1:0] rdy;
  logic [1:0] txl;
  logic [7:0] dat [2];

  int incv [2];
  int flen [2];

  // lane 0: even parity, two stop bits; lane 1: odd parity, one stop bit
  serial_tx #(.DATA_W(8), .ACC_W(ACC_W), .PARITY(PAR_EVEN), .STOP_BITS(2)) uut (
    .clk(clk), .rst(rst), .baud_inc(8'd37), .in_valid(vld[0]), .in_data(dat[0]),
    .in_ready(rdy[0]), .tx(txl[0]));

  serial_tx #(.DATA_W(8), .ACC_W(ACC_W), .PARITY(PAR_ODD), .STOP_BITS(1)) uut_odd (
    .clk(clk), .rst(rst), .baud_inc(8'd100), .in_valid(vld[1]), .in_data(dat[1]),
    .in_ready(rdy[1]), .tx(txl[1]));

  int tests = 0;
  int fails = 0;

  function automatic logic [7:0] byte_at(int p);
    case (p)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h01;
      3: return 8'h80;
      4: return 8'h55;
      default: return 8'((p * 53 + 17) & 255);
    endcase
  endfunction

  function automatic int gap_of(int p);
    return (p < 8) ? 0 : (p % 3) * 7;
  endfunction

  // Reference frame from R2/R3/R4, bit 0 first on the line
  function automatic logic [15:0] build(int l, logic [7:0] b);
    logic [15:0] f;
    logic        p;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = b;
    p = (^b) ^ (l == 1);
    f[9] = p;
    return f;
  endfunction

  logic [15:0] fb   [2];
  logic [1:0]  act, rs;
  int          m    [2];
  int          ptr  [2];
  int          nfr  [2];
  int          hold [2];
  int          cyc;
  bit          done;

  initial begin
    incv = '{37, 100};
    flen = '{12, 11};
    vld = '0; rs = '0; act = '0;
    dat[0] = 8'h00; dat[1] = 8'h00;
    for (int l = 0; l < 2; l++) begin
      m[l] = 0; ptr[l] = 0; nfr[l] = 0; hold[l] = 0; fb[l] = '1;
    end
    cyc = 0; done = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > WD) begin
        fails++; tests++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected <=%0d", cyc, WD);
        break;
      end
      for (int l = 0; l < 2; l++) begin
        int idx;
        int nidx;
        logic exp_tx;
        logic exp_rdy;
        // account for the edge just passed (R8: only accepted bytes count)
        if (vld[l] && rs[l]) begin
          fb[l] = build(l, dat[l]);
          act[l] = 1'b1;
          m[l] = 0;
          ptr[l]++;
          nfr[l]++;
          hold[l] = cyc + gap_of(ptr[l]);
        end else if (act[l]) begin
          m[l]++;
        end
        idx  = (m[l] * incv[l]) >> ACC_W;
        nidx = ((m[l] + 1) * incv[l]) >> ACC_W;
        exp_tx  = (act[l] && idx < flen[l]) ? fb[l][idx] : 1'b1;
        exp_rdy = !act[l] || (nidx >= flen[l]);
        tests++;
        if (txl[l] !== exp_tx) begin
          fails++;
          if (!act[l] || idx >= flen[l])
            $display("FAIL R1 lane%0d cyc%0d: tx actual=%b expected=%b", l, cyc, txl[l], exp_tx);
          else if (idx == 0)
            $display("FAIL R6 lane%0d cyc%0d: tx actual=%b expected=%b", l, cyc, txl[l], exp_tx);
          else if (idx == 9 && l == 0)
            $display("FAIL R3 lane%0d cyc%0d: tx actual=%b expected=%b", l, cyc, txl[l], exp_tx);
          else if (idx == 9)
            $display("FAIL R4 lane%0d cyc%0d: tx actual=%b expected=%b", l, cyc, txl[l], exp_tx);
          else
            $display("FAIL R2/R5 lane%0d cyc%0d bit%0d: tx actual=%b expected=%b",
                     l, cyc, idx, txl[l], exp_tx);
        end
        tests++;
        if (rdy[l] !== exp_rdy) begin
          fails++;
          $display("FAIL R7 lane%0d cyc%0d: in_ready actual=%b expected=%b", l, cyc, rdy[l], exp_rdy);
        end
        if (act[l] && idx >= flen[l]) act[l] = 1'b0;
        // drive next stimulus; scrambled data while not offering (R8)
        if (ptr[l] < NB && cyc >= hold[l]) begin
          vld[l] = 1'b1;
          dat[l] = byte_at(ptr[l]);
        end else begin
          vld[l] = 1'b0;
          dat[l] = 8'hA5 ^ 8'(cyc);
        end
        rs[l] = rdy[l];
      end
      done = (ptr[0] == NB) && (ptr[1] == NB) && !act[0] && !act[1] && !vld[0] && !vld[1];
    end
    // R8: one frame per offered byte, none lost or duplicated
    for (int l = 0; l < 2; l++) begin
      tests++;
      if (nfr[l] != NB) begin
        fails++;
        $display("FAIL R8 lane%0d: frames actual=%0d expected=%0d", l, nfr[l], NB);
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule